// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for a signal-processing core. Every clock it can multiply two 16-bit operands and fold the 32-bit product into a 40-bit accumulator. The accumulator has eight guard bits above the 32-bit product range, so long sums of products can grow past full scale without wrapping. Each operand is read as two's complement or as unsigned, chosen separately for each operation. A mode input selects integer products or fractional (1.15 × 1.15) products. In fractional mode the product is moved left one place so that the result lands in 1.31 form.

The operation code selects one of four ways to update the accumulator: take the product, add it, subtract it, or clear to zero. A fifth code asks for a conditional saturation. When the accumulator has left the 32-bit range, that command clamps it to the nearest 32-bit full-scale value. A round request adds half an LSB of the middle word to the result of a product operation. An overflow flag shows whether the accumulator currently holds a value beyond 32-bit range. The accumulator is viewed as a low 16-bit word (bits 15:0), a middle 16-bit word (bits 31:16) and an 8-bit guard word (bits 39:32).

The operation decoder is a one-cycle command machine. The accumulator register is its state, and the operation code picks the transition at each clock edge. The transitions are: hold (NOP and unused codes), load (LOAD), accumulate (ADD), deduct (SUB), zero (CLEAR) and clamp (SAT, taken only while the flag is set).

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `acc_o` is 0 and `ovf_o` is 0 until the first operation.
- R2: Op code 3'd1 (LOAD) sets `acc_o` to the extended product on the next rising edge.
- R3: Op code 3'd2 (ADD) sets `acc_o` to the previous accumulator plus the extended product, modulo 2^40.
- R4: Op code 3'd3 (SUB) sets `acc_o` to the previous accumulator minus the extended product, modulo 2^40.
- R5: Op code 3'd4 (CLEAR) sets `acc_o` to 0 and `ovf_o` to 0, whatever their earlier values and the round request.
- R6: `a_signed_i`=1 makes `a_i` two's complement and 0 makes it unsigned; `b_signed_i` does the same for `b_i`. All four combinations are allowed.
- R7: `frac_i`=1 shifts the 32-bit product left one bit and drops its top bit. `frac_i`=0 leaves the product unshifted.
- R8: The extended product is the low 32 bits of the (possibly shifted) product, read as signed and sign-extended to 40 bits. For example, 0xFFFF × 0xFFFF unsigned gives 0xFFFFFE0001.
- R9: After every update, `ovf_o` is 1 exactly when bits 39:31 of `acc_o` are neither all zero nor all one.
- R10: With `round_i`=1, LOAD, ADD and SUB add 0x8000 to the 40-bit result and leave bits 15:0 as the sum gives them. `round_i` has no effect on any other op code.
- R11: Op code 3'd5 (SAT) with `ovf_o`=1 sets `acc_o` to 0x007FFFFFFF if bit 39 is 0, or to 0xFF80000000 if bit 39 is 1, and then `ovf_o` reads 0.
- R12: Op code 3'd5 (SAT) with `ovf_o`=0 leaves `acc_o` and `ovf_o` unchanged.
- R13: Op code 3'd0 (NOP) and the unused codes 3'd6 and 3'd7 leave `acc_o` and `ovf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| a_i | input | 16 | First multiplicand |
| b_i | input | 16 | Second multiplicand |
| a_signed_i | input | 1 | 1: `a_i` is two's complement |
| b_signed_i | input | 1 | 1: `b_i` is two's complement |
| frac_i | input | 1 | 1: fractional product (shift left one) |
| round_i | input | 1 | 1: add 0x8000 to a product result |
| acc_o | output | 40 | Accumulator |
| ovf_o | output | 1 | Accumulator beyond 32-bit range |

## Verification
Every command acts on the rising edge that follows its issue. Its effect on `acc_o` and `ovf_o` is therefore due exactly one edge later, with no further pipeline stage. The bench drives each command on a falling edge and lets the reference model take the same command at the next rising edge. It compares both outputs at the falling edge after that, so each comparison sees the result of exactly one command. Saturation depends on the flag left by the previous command, so the bench first builds up positive and negative overflows through repeated accumulation. It then issues the clamp.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_CLEAR = 3'd4,
        OP_SAT   = 3'd5
    } mac_op_e;
endpackage

// File: rtl/mac_product.sv
// Forms the multiplier product and extends it to accumulator width.
module mac_product #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic             a_signed_i,
    input  logic             b_signed_i,
    input  logic             frac_i,
    output logic [ACC_W-1:0] prod_ext_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = OP_W + 1;
    localparam int GUARD  = ACC_W - PROD_W;

    logic signed [EXT_W-1:0]   a_x;
    logic signed [EXT_W-1:0]   b_x;
    logic signed [2*EXT_W-1:0] full;
    logic [PROD_W-1:0]         raw;
    logic [PROD_W-1:0]         aligned;

    always_comb begin
        // one extra bit lets signed and unsigned operands share one multiplier
        a_x        = {a_signed_i & a_i[OP_W-1], a_i};
        b_x        = {b_signed_i & b_i[OP_W-1], b_i};
        full       = a_x * b_x;
        raw        = full[PROD_W-1:0];
        aligned    = frac_i ? {raw[PROD_W-2:0], 1'b0} : raw;
        prod_ext_o = {{GUARD{aligned[PROD_W-1]}}, aligned};
    end
endmodule

// File: rtl/mac_range_detect.sv
// Flags an accumulator value whose top bits are not a uniform sign field.
module mac_range_detect #(
    parameter int ACC_W  = 40,
    parameter int PROD_W = 32
) (
    input  logic [ACC_W-1:0] value_i,
    output logic             out_of_range_o
);
    localparam int TOP_LSB = PROD_W - 1;

    logic [ACC_W-1:TOP_LSB] top;

    always_comb begin
        top            = value_i[ACC_W-1:TOP_LSB];
        out_of_range_o = (|top) && !(&top);
    end
endmodule

// File: rtl/mac_next_state.sv
// Decodes the command into the next accumulator value.
module mac_next_state #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [2:0]       op_i,
    input  logic             round_i,
    input  logic [ACC_W-1:0] acc_q_i,
    input  logic             ovf_q_i,
    input  logic [ACC_W-1:0] prod_ext_i,
    output logic [ACC_W-1:0] acc_d_o,
    output logic             load_o
);
    import mac_pkg::*;

    localparam int PROD_W = 2 * OP_W;
    localparam int GUARD  = ACC_W - PROD_W;
    localparam logic [ACC_W-1:0] SAT_POS   = {{(GUARD+1){1'b0}}, {(PROD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_NEG   = {{(GUARD+1){1'b1}}, {(PROD_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] ROUND_INC = ACC_W'(1) << (OP_W - 1);

    mac_op_e          op;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] rnd;

    always_comb begin
        op      = mac_op_e'(op_i);
        base    = '0;
        load_o  = 1'b0;
        rnd     = round_i ? ROUND_INC : '0;
        acc_d_o = acc_q_i;
        unique case (op)
            OP_LOAD: begin
                base   = prod_ext_i;
                load_o = 1'b1;
            end
            OP_ADD: begin
                base   = acc_q_i + prod_ext_i;
                load_o = 1'b1;
            end
            OP_SUB: begin
                base   = acc_q_i - prod_ext_i;
                load_o = 1'b1;
            end
            OP_CLEAR: begin
                rnd    = '0;
                load_o = 1'b1;
            end
            OP_SAT: begin
                rnd    = '0;
                if (ovf_q_i) begin
                    base   = acc_q_i[ACC_W-1] ? SAT_NEG : SAT_POS;
                    load_o = 1'b1;
                end
            end
            default: begin
                rnd    = '0;
            end
        endcase
        if (load_o) begin
            acc_d_o = base + rnd;
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic             a_signed_i,
    input  logic             b_signed_i,
    input  logic             frac_i,
    input  logic             round_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    localparam int PROD_W = 2 * OP_W;

    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_d;
    logic             load;
    logic             ovf_d;

    mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_product (
        .a_i        (a_i),
        .b_i        (b_i),
        .a_signed_i (a_signed_i),
        .b_signed_i (b_signed_i),
        .frac_i     (frac_i),
        .prod_ext_o (prod_ext)
    );

    mac_next_state #(.OP_W(OP_W), .ACC_W(ACC_W)) u_next (
        .op_i       (op_i),
        .round_i    (round_i),
        .acc_q_i    (acc_q),
        .ovf_q_i    (ovf_q),
        .prod_ext_i (prod_ext),
        .acc_d_o    (acc_d),
        .load_o     (load)
    );

    mac_range_detect #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_range (
        .value_i        (acc_d),
        .out_of_range_o (ovf_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
        end
    end

    always_comb begin
        acc_o = acc_q;
        ovf_o = ovf_q;
    end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             ovf_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam int GUARD  = ACC_W - PROD_W;
    localparam logic [ACC_W-1:0] POS_FS = {{(GUARD+1){1'b0}}, {(PROD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_FS = {{(GUARD+1){1'b1}}, {(PROD_W-1){1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (acc_o == '0 && !ovf_o));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o == ((|acc_o[ACC_W-1:PROD_W-1]) && !(&acc_o[ACC_W-1:PROD_W-1])));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd4 |=> (acc_o == '0 && !ovf_o));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> ($stable(acc_o) && $stable(ovf_o)));

    // R11
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && ovf_o) |=> ((acc_o == POS_FS || acc_o == NEG_FS) && !ovf_o));

    // R11
    clamp_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && ovf_o && acc_o[ACC_W-1]) |=> acc_o == NEG_FS);

    // R12
    clamp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && !ovf_o) |=> ($stable(acc_o) && $stable(ovf_o)));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .acc_o (acc_o),
    .ovf_o (ovf_o)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        a_s = 1'b0;
    logic        b_s = 1'b0;
    logic        frac = 1'b0;
    logic        rnd = 1'b0;
    logic [39:0] acc;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [39:0] m_acc = '0;
    logic        m_ovf = 1'b0;

    always #5 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .a_signed_i(a_s), .b_signed_i(b_s), .frac_i(frac), .round_i(rnd),
        .acc_o(acc), .ovf_o(ovf)
    );

    function automatic longint model_prod(input logic [15:0] x, input logic [15:0] y,
                                          input bit xs, input bit ys, input bit fr);
        longint xv = xs ? longint'($signed(x)) : longint'(x);
        longint yv = ys ? longint'($signed(y)) : longint'(y);
        longint p = (xv * yv) & 64'hFFFF_FFFF;
        if (fr) p = (p * 2) & 64'hFFFF_FFFF;
        if (p >= 64'sh8000_0000) p = p - 64'sh1_0000_0000;
        return p;
    endfunction

    function automatic bit model_range(input logic [39:0] v);
        logic [8:0] t = v[39:31];
        return (t != 9'h000) && (t != 9'h1FF);
    endfunction

    task automatic model_update();
        longint cur = m_acc[39] ? longint'(m_acc) - (64'sd1 <<< 40) : longint'(m_acc);
        longint pr = model_prod(a, b, a_s, b_s, frac);
        longint s = 0;
        bit upd = 1;
        case (op)
            3'd1: s = pr;
            3'd2: s = cur + pr;
            3'd3: s = cur - pr;
            3'd4: s = 0;
            3'd5: begin
                if (m_ovf) s = m_acc[39] ? -(64'sd1 <<< 31) : (64'sd1 <<< 31) - 1;
                else upd = 0;
            end
            default: upd = 0;
        endcase
        if (upd) begin
            if (rnd && (op == 3'd1 || op == 3'd2 || op == 3'd3)) s = s + 32768;
            m_acc = s[39:0];
            m_ovf = model_range(m_acc);
        end
    endtask

    task automatic compare(input string req);
        checks++;
        if (acc !== m_acc || ovf !== m_ovf) begin
            errors++;
            $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", req, acc, ovf, m_acc, m_ovf);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                        input bit xs, input bit ys, input bit fr, input bit r, input string req);
        op = o; a = x; b = y; a_s = xs; b_s = ys; frac = fr; rnd = r;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(req);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: acc=%h expected completion", acc);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2 integer signed load: 3 * -4
        step(3'd1, 16'd3, 16'hFFFC, 1, 1, 0, 0, "R2 load");
        // R3 accumulate
        step(3'd2, 16'd100, 16'd7, 1, 1, 0, 0, "R3 add");
        // R4 deduct
        step(3'd3, 16'h0200, 16'h0010, 1, 1, 0, 0, "R4 sub");
        // R6 mixed signedness: -1 * 65535
        step(3'd1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, "R6 signed x unsigned");
        step(3'd1, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, "R6 unsigned x signed");
        step(3'd1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, "R6 signed x signed");
        // R8 unsigned product beyond 31 bits wraps into a negative extension
        step(3'd1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R8 unsigned x unsigned");
        // R7 fractional products
        step(3'd1, 16'h4000, 16'h4000, 1, 1, 1, 0, "R7 half x half");
        step(3'd1, 16'h8000, 16'h8000, 1, 1, 1, 0, "R7 minus one squared");
        step(3'd1, 16'h4000, 16'h4000, 1, 1, 0, 0, "R7 integer reference");
        // R10 rounding
        step(3'd1, 16'd1, 16'd1, 1, 1, 0, 1, "R10 round load");
        step(3'd2, 16'd1, 16'h7FFF, 1, 1, 0, 1, "R10 round add");
        step(3'd0, 16'd5, 16'd5, 1, 1, 0, 1, "R10 round on nop ignored");
        // R12 clamp while in range
        step(3'd5, 16'd0, 16'd0, 1, 1, 0, 1, "R12 sat without overflow");
        // R9 positive overflow build-up
        step(3'd1, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R9 load near full scale");
        for (int i = 0; i < 3; i++)
            step(3'd2, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R9 positive growth");
        // R13 hold with flag set
        step(3'd0, 16'h1234, 16'h5678, 1, 1, 0, 0, "R13 nop");
        step(3'd6, 16'h1234, 16'h5678, 1, 1, 0, 0, "R13 code 6");
        step(3'd7, 16'h1234, 16'h5678, 1, 1, 0, 0, "R13 code 7");
        // R11 clamp positive
        step(3'd5, 16'd0, 16'd0, 1, 1, 0, 0, "R11 sat positive");
        // R9 negative overflow build-up
        step(3'd1, 16'h8000, 16'h7FFF, 1, 1, 1, 0, "R9 load negative");
        for (int i = 0; i < 3; i++)
            step(3'd2, 16'h8000, 16'h7FFF, 1, 1, 1, 0, "R9 negative growth");
        // R11 clamp negative
        step(3'd5, 16'd0, 16'd0, 1, 1, 0, 0, "R11 sat negative");
        // R5 clear with flag set
        step(3'd1, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R9 reload");
        for (int i = 0; i < 2; i++)
            step(3'd2, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R9 regrowth");
        step(3'd4, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, "R5 clear");
        // R4 deduct into negative and guard region
        for (int i = 0; i < 3; i++)
            step(3'd3, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R4 sub growth");

        // mixed traffic against the reference model
        for (int i = 0; i < 400; i++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            step(o, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), "R3 mixed traffic");
        end

        done = 1;
        report();
    end
endmodule